// File: doc/BRIEF.md
# Half-Band Decimate-by-Two Filter Stage

This block is one 2:1 decimation stage built on a half-band FIR response. Samples come in with a one-cycle valid strobe and are written into a circular history buffer. Every second accepted sample starts the computation of one output. A single multiply-accumulate unit produces that output by stepping through only the taps that can be non-zero. Several stages of the same structure can be chained to reach higher decimation ratios, for example after the comb filter of an oversampling converter.

The impulse response is symmetric and has an odd length of the form 4N+3. Only the centre tap and the taps at an odd distance from the centre carry weight, so the stage stores one coefficient per distinct magnitude of offset. Taps at +k and -k read the same stored word. Entry 0 of the table is the centre weight, and entry j (for j of 1 or more) is the weight at offset 2j-1. The sum of products is kept in a wide accumulator, rounded back to the sample width, and clipped to that width.

The controller has three states. `S_IDLE` waits for the second sample of a pair. `S_ACC` performs one multiply-accumulate per cycle. `S_DONE` presents the result. The transitions are IDLE→ACC on a pair-completing sample, ACC→ACC while steps remain, ACC→DONE after the last step, and DONE→IDLE unconditionally. The stage has no back-pressure. A pair-completing sample that arrives outside `S_IDLE` is counted as an overrun.

Top module: `hb_decim`

## Requirements
- R1: Exactly one output is produced for each pair of accepted input samples. The 2nd, 4th, 6th, … sample after reset starts a computation, and the 1st, 3rd, … samples never do.
- R2: The output equals the sum over all taps k of h[k]·x[n−k], where x[n] is the sample that completed the pair and samples before reset count as zero. h is symmetric about centre C=(NTAPS−1)/2. h[C] is table entry 0, h[C±(2j−1)] is table entry j, and every other tap is zero.
- R3: A pair-completing sample that arrives while the controller is outside `S_IDLE` sets `overrun`. That output is dropped, and `overrun` stays at 1 until reset.
- R4: `out_valid` is a single-cycle pulse. It is asserted on the edge (NTAPS+1)/2+2 clock edges after the edge that captured the pair-completing sample, because each of the (NTAPS+1)/2+1 non-zero taps takes one cycle.
- R5: Rounding adds 2^(CW−2) to the accumulator and then shifts it arithmetically right by CW−1, so an exact half LSB rounds toward plus infinity.
- R6: Results above 2^(DW−1)−1 or below −2^(DW−1) are clipped to those limits.
- R7: The accumulator is cleared at the start of every output computation, so no output carries residue from an earlier one.
- R8: Reset clears the output, `out_valid`, `overrun`, the pair phase and the entire sample history to zero.
- R9: An unpaired sample may arrive during a computation without effect on it. Computations that start (NTAPS+1)/2+3 cycles apart all complete without `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe, one cycle per sample |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | One-cycle strobe for a new output |
| out_data | output | DW | Signed, rounded and clipped output |
| overrun | output | 1 | Sticky flag: a computation request arrived while busy |

## Verification
The bench runs a 7-tap build whose weights sum above unity. This configuration reaches the clip limits in both directions. A design that wrapped instead of clipping would flip the sign of the output there. Impulses placed on both input phases read the whole decimated impulse response back out. Any swap of the mirror index or any use of a zero-position tap shows up as a wrong value at a specific output. The bench checks that zeros following a run of saturated outputs give a result of exactly zero, which catches an accumulator that is not cleared. Small integer inputs hit the exact half-LSB tie. Trigger spacings one cycle apart on either side of the busy window separate a correct overrun detector from one that is off by one cycle, and the output count confirms that the dropped request produces no output.

// File: rtl/hb_decim_pkg.sv
package hb_decim_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_ACC  = 2'd1,
        S_DONE = 2'd2
    } hb_state_e;

endpackage

// File: rtl/hb_sample_ring.sv
module hb_sample_ring #(
    parameter int DW    = 24,
    parameter int DEPTH = 32,
    parameter int PW    = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic signed [DW-1:0] wr_data,
    input  logic [PW-1:0]        rd_addr,
    output logic [PW-1:0]        wr_ptr,
    output logic signed [DW-1:0] rd_data
);

    logic signed [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_ptr] <= wr_data;
            wr_ptr      <= wr_ptr + 1'b1;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/hb_tap_seq.sv
module hb_tap_seq #(
    parameter int                    NTAPS = 19,
    parameter int                    CW    = 24,
    parameter int                    NUNIQ = 6,
    parameter int                    PW    = 5,
    parameter int                    SW    = 4,
    parameter logic [NUNIQ*CW-1:0]   COEFS = '0
) (
    input  logic [SW-1:0]        step,
    output logic [PW-1:0]        tap_k,
    output logic signed [CW-1:0] coef
);

    localparam int NSIDE = (NTAPS + 1) / 2;
    localparam int CTR   = (NTAPS - 1) / 2;

    int s;
    int k;
    int d;
    int j;

    always_comb begin
        s = int'(step);
        k = CTR;
        d = 0;
        j = 0;
        if (s < NSIDE) begin
            k = 2 * s;
            d = (k > CTR) ? (k - CTR) : (CTR - k);
            j = (d + 1) / 2;
        end
        tap_k = PW'(k);
        coef  = COEFS[j*CW +: CW];
    end

endmodule

// File: rtl/hb_mac.sv
module hb_mac #(
    parameter int DW = 24,
    parameter int CW = 24,
    parameter int AW = 56
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 en,
    input  logic signed [DW-1:0] sample,
    input  logic signed [CW-1:0] coef,
    output logic signed [AW-1:0] acc
);

    localparam int PRW = DW + CW;

    logic signed [PRW-1:0] prod;
    logic signed [AW-1:0]  prod_ext;

    assign prod     = sample * coef;
    assign prod_ext = {{(AW-PRW){prod[PRW-1]}}, prod};

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc <= '0;
        end else if (en) begin
            acc <= acc + prod_ext;
        end
    end

endmodule

// File: rtl/hb_decim.sv
module hb_decim
    import hb_decim_pkg::*;
#(
    parameter int NTAPS = 19,
    parameter int DW    = 24,
    parameter int CW    = 24,
    parameter int AW    = 56,
    parameter logic [((NTAPS+1)/4+1)*CW-1:0] COEFS = {
        24'h0147AE, 24'hFCCCCD, 24'h066666,
        24'hF33333, 24'h266666, 24'h400000
    }
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          overrun
);

    localparam int NUNIQ = (NTAPS + 1) / 4 + 1;
    localparam int NMAC  = (NTAPS + 1) / 2 + 1;
    localparam int DEPTH = 2 ** $clog2(NTAPS + 2);
    localparam int PW    = $clog2(DEPTH);
    localparam int SW    = $clog2(NMAC + 1);
    localparam int FRAC  = CW - 1;
    localparam logic signed [AW-1:0] RND  = AW'(1) <<< (FRAC - 1);
    localparam logic signed [AW-1:0] MAXV = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [AW-1:0] MINV = ~MAXV;

    hb_state_e state;
    hb_state_e state_nx;

    logic                 phase;
    logic                 trigger;
    logic                 start;
    logic [SW-1:0]        step;
    logic [PW-1:0]        base;
    logic [PW-1:0]        wr_ptr;
    logic [PW-1:0]        tap_k;
    logic signed [DW-1:0] rd_data;
    logic signed [CW-1:0] coef;
    logic signed [AW-1:0] acc;
    logic signed [AW-1:0] biased;
    logic signed [AW-1:0] shifted;
    logic [DW-1:0]        result;

    assign trigger = in_valid && phase;
    assign start   = trigger && (state == S_IDLE);

    hb_sample_ring #(.DW(DW), .DEPTH(DEPTH), .PW(PW)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (in_valid),
        .wr_data (in_data),
        .rd_addr (base - tap_k),
        .wr_ptr  (wr_ptr),
        .rd_data (rd_data)
    );

    hb_tap_seq #(
        .NTAPS(NTAPS), .CW(CW), .NUNIQ(NUNIQ),
        .PW(PW), .SW(SW), .COEFS(COEFS)
    ) u_seq (
        .step  (step),
        .tap_k (tap_k),
        .coef  (coef)
    );

    hb_mac #(.DW(DW), .CW(CW), .AW(AW)) u_mac (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (start),
        .en     (state == S_ACC),
        .sample (rd_data),
        .coef   (coef),
        .acc    (acc)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (trigger) state_nx = S_ACC;
            S_ACC:   if (step == SW'(NMAC - 1)) state_nx = S_DONE;
            S_DONE:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // Round half up, then clip to the sample range
    always_comb begin
        biased  = acc + RND;
        shifted = biased >>> FRAC;
        if (shifted > MAXV) begin
            result = MAXV[DW-1:0];
        end else if (shifted < MINV) begin
            result = MINV[DW-1:0];
        end else begin
            result = shifted[DW-1:0];
        end
    end

    // Outputs and sequencing registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= 1'b0;
            step      <= '0;
            base      <= '0;
            overrun   <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            if (in_valid) begin
                phase <= ~phase;
            end
            if (start) begin
                base <= wr_ptr;
                step <= '0;
            end else if (state == S_ACC) begin
                step <= step + 1'b1;
            end
            if (trigger && (state != S_IDLE)) begin
                overrun <= 1'b1;
            end
            out_valid <= (state == S_DONE);
            if (state == S_DONE) begin
                out_data <= result;
            end
        end
    end

endmodule

// File: rtl/hb_decim_chk.sv
module hb_decim_chk
    import hb_decim_pkg::*;
#(
    parameter int NMAC = 11,
    parameter int SW   = 4,
    parameter int AW   = 56
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 out_valid,
    input logic                 overrun,
    input hb_state_e            state,
    input logic [SW-1:0]        step,
    input logic signed [AW-1:0] acc
);

    // R4: output strobe lasts one cycle
    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R4: result only after a full accumulation
    p_done_after_acc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DONE) |-> ($past(state) == S_ACC));

    // R4: step counter stays inside the tap schedule
    p_step_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ACC) |-> (step < SW'(NMAC)));

    // R3: overrun never clears without reset
    p_overrun_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    // R3: overrun only rises while a computation is in flight
    p_overrun_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> ($past(state) != S_IDLE));

    // R7: every computation starts from an empty accumulator
    p_acc_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_ACC) && (step == '0)) |-> (acc == '0));

endmodule

bind hb_decim hb_decim_chk #(.NMAC(NMAC), .SW(SW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .overrun   (overrun),
    .state     (state),
    .step      (step),
    .acc       (acc)
);

// File: tb/hb_decim_bench.sv
`timescale 1ns/1ps
module hb_decim_bench;

    localparam int NT = 7;
    localparam int NM = (NT + 1) / 2 + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [23:0] in_data = '0;
    logic        out_valid;
    logic [23:0] out_data;
    logic        overrun;

    always #2.5 clk = ~clk;

    hb_decim #(
        .NTAPS(NT),
        .COEFS({24'hD9999A, 24'h733333, 24'h400000})
    ) u_hb_decim (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data), .overrun(overrun)
    );

    int h [NT];
    int x_hist [0:4095];
    int n_in;
    int cyc;
    int total;
    int bad;
    int out_cnt;
    bit chk_on;
    bit done;
    string cur_req;
    int exp_q [$];
    int cyc_q [$];
    int unsigned lfsr;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int model_out(int n);
        longint acc = 0;
        longint r;
        for (int k = 0; k < NT; k++) begin
            if (n - k >= 0) acc += longint'(h[k]) * longint'(x_hist[n-k]);
        end
        r = (acc + 64'sd4194304) >>> 23;
        if (r > 8388607) r = 8388607;
        if (r < -8388608) r = -8388608;
        return int'(r);
    endfunction

    function automatic int next_rand();
        lfsr ^= lfsr << 13;
        lfsr ^= lfsr >> 17;
        lfsr ^= lfsr << 5;
        return int'(lfsr & 32'h00FF_FFFF) - ((lfsr & 32'h0080_0000) != 0 ? 16777216 : 0);
    endfunction

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            out_cnt++;
            if (chk_on) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1", "unexpected output", 1, 0);
                end else begin
                    int e;
                    int c;
                    int got;
                    e = exp_q.pop_front();
                    c = cyc_q.pop_front();
                    got = int'($signed(out_data));
                    check(got == e, cur_req, "output value", got, e);
                    check(cyc == c, "R4", "output cycle", cyc, c);
                end
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        n_in = 0;
        out_cnt = 0;
        exp_q.delete();
        cyc_q.delete();
    endtask

    task automatic send(int v, int gap);
        @(negedge clk);
        in_valid = 1'b1;
        in_data = v[23:0];
        x_hist[n_in] = v;
        if ((n_in % 2) == 1 && chk_on) begin
            exp_q.push_back(model_out(n_in));
            cyc_q.push_back(cyc + NM + 2);
        end
        n_in++;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (gap - 2) @(negedge clk);
    endtask

    task automatic drain(string req);
        repeat (NM + 6) @(negedge clk);
        check(exp_q.size() == 0, req, "missing outputs", exp_q.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        h[0] = -2516582; h[1] = 0; h[2] = 7549747; h[3] = 4194304;
        h[4] = 7549747;  h[5] = 0; h[6] = -2516582;
        lfsr = 32'h1234_5678;
        chk_on = 1'b1;
        cur_req = "R2";
        do_reset();

        // R8: reset state at the ports
        check(out_valid == 1'b0, "R8", "out_valid after reset", out_valid, 0);
        check(out_data == '0, "R8", "out_data after reset", out_data, 0);
        check(overrun == 1'b0, "R8", "overrun after reset", overrun, 0);

        // R2: impulse on the first phase, then on the second phase
        cur_req = "R2";
        send(4194304, 4);
        for (int i = 0; i < 9; i++) send(0, 4);
        send(0, 4);
        send(4194304, 4);
        for (int i = 0; i < 10; i++) send(0, 4);
        drain("R1");

        // R6: clip at both ends
        cur_req = "R6";
        for (int i = 0; i < 12; i++) send(8388607, 4);
        // R7: zeros after saturated outputs must give exactly zero
        cur_req = "R7";
        for (int i = 0; i < 8; i++) send(0, 4);
        cur_req = "R6";
        for (int i = 0; i < 12; i++) send(-8388608, 4);
        for (int i = 0; i < 12; i++) send((i % 2 == 0) ? 8388607 : -8388608, 4);
        cur_req = "R7";
        for (int i = 0; i < 8; i++) send(0, 4);
        drain("R1");

        // R5: small values hit the half-LSB tie and its neighbours
        cur_req = "R5";
        for (int v = -8; v <= 8; v++) begin
            send(v, 4);
            send(0, 4);
            send(0, 4);
            send(0, 4);
        end
        drain("R1");

        // R2: ramp sweep and pseudo-random data
        cur_req = "R2";
        for (int i = 0; i < 40; i++) send(i * 37449 - 4194304, 4);
        for (int i = 0; i < 200; i++) send(next_rand(), 4);
        drain("R1");

        // R9: trigger spacing of NM+2 cycles, unpaired sample mid-computation
        cur_req = "R9";
        for (int i = 0; i < 40; i++) send(next_rand(), (i % 2 == 0) ? 3 : 4);
        drain("R9");
        check(overrun == 1'b0, "R9", "no overrun at minimum spacing", overrun, 0);

        // R3: trigger spacing one cycle short of the busy window
        do_reset();
        chk_on = 1'b0;
        for (int i = 0; i < 4; i++) send(next_rand(), 3);
        repeat (20) @(negedge clk);
        check(overrun == 1'b1, "R3", "overrun set", overrun, 1);
        check(out_cnt == 1, "R3", "dropped output count", out_cnt, 1);
        send(1000, 8);
        send(2000, 8);
        repeat (20) @(negedge clk);
        check(overrun == 1'b1, "R3", "overrun sticky", overrun, 1);
        check(out_cnt == 2, "R1", "output after overrun", out_cnt, 2);

        // R8: reset clears the flag and the history
        do_reset();
        check(overrun == 1'b0, "R8", "overrun cleared", overrun, 0);
        chk_on = 1'b1;
        cur_req = "R8";
        send(0, 4);
        send(0, 4);
        drain("R8");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule